// File: doc/BRIEF.md
# Write-Protect Group Manager

This block keeps one protect bit for each group of sectors in a storage array. It accepts three kinds of request: set a group's bit, clear a group's bit, and query a run of bits. A query returns the 32 bits starting at the addressed group, then a 16-bit CRC, in the same way as a single-block read. Requests carry a byte address. The group size is given as a power-of-two count of 512-byte sectors, and every address bit below the group boundary is ignored.

A separate combinational check port gives a write permit for any byte address. It combines the group bits with three controls that cover the whole card: a permanent protect bit, a temporary protect bit, and a host-side switch input. Any of the three blocks writes everywhere, and none of them changes the stored bits.

The request input and the serial response output are both valid/ready streams. A request is accepted on a rising edge when `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after a query is accepted until its last bit is taken, so only one response can be pending at a time. A response bit is consumed on a rising edge when `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the bit on offer is held unchanged.

Top module: `wp_group_mgr`

## Requirements
- R1: After reset all 64 group bits are clear, `req_ready` is high and `rsp_valid` is low.
- R2: The group of an address is `addr >> (9 + grp_sz)`. Address bits below that boundary have no effect on which group is selected.
- R3: With `grp_en` high, an accepted request with op code 0 sets the addressed group's bit and op code 1 clears it. No other bit changes. The new value is visible from the cycle after acceptance.
- R4: With `grp_en` low, set and clear requests leave every bit unchanged, and the group bits do not affect `wr_permit`.
- R5: `wr_permit` is low whenever `perm_wp`, `temp_wp` or `sw_wp` is high, whatever the group bits are. These inputs never modify the group bits.
- R6: Otherwise `wr_permit` is low exactly when `grp_en` is high and the bit of the group selected by `chk_addr` is set. Groups numbered 64 or above count as unprotected.
- R7: An accepted request with op code 2 (query) puts out, starting the next cycle, 32 bits for groups base, base+1, …, base+31, in that order. Groups beyond 63 read as 0.
- R8: The 32 data bits are followed by a 16-bit CRC, sent most significant bit first. The CRC uses polynomial 0x1021 with initial value 0 and covers the data bits in the order they were sent. `rsp_last` is high only on the 48th bit.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_bit` and `rsp_last` hold their values. `req_ready` is low while a response is pending.
- R10: A request with op code 3, or a set or clear that targets a group of 64 or above, changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 set, 1 clear, 2 query, 3 no operation |
| req_addr | input | 32 | Byte address of the request |
| grp_sz | input | 4 | log2 of the number of sectors per group |
| grp_en | input | 1 | Enables per-group protection |
| perm_wp | input | 1 | Permanent whole-card protection |
| temp_wp | input | 1 | Temporary whole-card protection |
| sw_wp | input | 1 | Host-side protect switch |
| chk_addr | input | 32 | Byte address to test for write permission |
| wr_permit | output | 1 | Write or erase permitted at `chk_addr` |
| rsp_valid | output | 1 | Response bit offered |
| rsp_ready | input | 1 | Consumer takes the response bit |
| rsp_bit | output | 1 | Serial response data |
| rsp_last | output | 1 | Marks the final CRC bit |

## Verification
The assertions assume that `grp_sz`, `grp_en` and the protect controls change only between requests, and that `req_op` is valid whenever `req_valid` is high. The bench drives all controls at falling edges, and only while no response is pending. It also holds `req_valid` for exactly one accepted cycle. Back-pressure is applied by dropping `rsp_ready` in a fixed pattern while a query response is being collected.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_CLR = 2'd1,
    OP_QRY = 2'd2,
    OP_NOP = 2'd3
  } wpg_op_e;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  // One serial step of the CRC register for input bit b.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/wpg_index.sv
module wpg_index #(
  parameter int ADDR_W    = 32,
  parameter int SZ_W      = 4,
  parameter int BASE_LOG2 = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SZ_W-1:0]   sz,
  output logic [ADDR_W-1:0] gidx
);
  localparam int SH_W = 8;
  logic [SH_W-1:0] shamt;

  assign shamt = SH_W'(BASE_LOG2) + SH_W'(sz);
  assign gidx  = addr >> shamt;
endmodule

// File: rtl/wpg_table.sv
module wpg_table #(
  parameter int NGROUPS = 64,
  parameter int ADDR_W  = 32,
  parameter int WIN     = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [ADDR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0]  rd_idx,
  input  logic [ADDR_W-1:0]  base,
  output logic [NGROUPS-1:0] bits,
  output logic               rd_bit,
  output logic [WIN-1:0]     window
);
  localparam int GW = $clog2(NGROUPS);
  logic [NGROUPS-1:0] hit_vec;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        bits[g] <= 1'b0;
      else if (set_en && wr_idx == ADDR_W'(g))
        bits[g] <= 1'b1;
      else if (clr_en && wr_idx == ADDR_W'(g))
        bits[g] <= 1'b0;
    end
    assign hit_vec[g] = bits[g] && (rd_idx == ADDR_W'(g));
  end

  assign rd_bit = |hit_vec;

  for (genvar w = 0; w < WIN; w++) begin : g_win
    logic [ADDR_W:0] pos;
    assign pos       = {1'b0, base} + (ADDR_W+1)'(w);
    assign window[w] = (pos < (ADDR_W+1)'(NGROUPS)) ? bits[pos[GW-1:0]] : 1'b0;
  end
endmodule

// File: rtl/wpg_serializer.sv
module wpg_serializer
  import wpg_pkg::*;
#(
  parameter int WIN = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [WIN-1:0] data,
  input  logic           rsp_ready,
  output logic           rsp_valid,
  output logic           rsp_bit,
  output logic           rsp_last
);
  localparam int TOT = WIN + CRC_W;
  localparam int CW  = $clog2(TOT + 1);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [WIN-1:0]   shreg;
  logic [CRC_W-1:0] crc;
  logic             in_data;
  logic             take;

  assign in_data   = cnt < CW'(WIN);
  assign take      = busy && rsp_ready;
  assign rsp_valid = busy;
  assign rsp_bit   = in_data ? shreg[0] : crc[CRC_W-1];
  assign rsp_last  = busy && (cnt == CW'(TOT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
      crc   <= '0;
    end else if (load && !busy) begin
      busy  <= 1'b1;
      cnt   <= '0;
      shreg <= data;
      crc   <= '0;
    end else if (take) begin
      if (in_data) begin
        crc   <= crc_step(crc, shreg[0]);
        shreg <= shreg >> 1;
      end else begin
        crc <= {crc[CRC_W-2:0], 1'b0};
      end
      cnt <= cnt + 1'b1;
      if (cnt == CW'(TOT - 1))
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/wp_group_mgr.sv
module wp_group_mgr
  import wpg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SZ_W      = 4,
  parameter int NGROUPS   = 64,
  parameter int WIN       = 32,
  parameter int BASE_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   grp_sz,
  input  logic              grp_en,
  input  logic              perm_wp,
  input  logic              temp_wp,
  input  logic              sw_wp,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              wr_permit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_bit,
  output logic              rsp_last
);
  logic [ADDR_W-1:0]  req_gidx;
  logic [ADDR_W-1:0]  chk_gidx;
  logic [NGROUPS-1:0] grp_bits;
  logic [WIN-1:0]     window;
  logic               rd_bit;
  logic               accept;
  wpg_op_e            op;

  assign op        = wpg_op_e'(req_op);
  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;

  wpg_index #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .BASE_LOG2(BASE_LOG2)) u_req_idx (
    .addr(req_addr), .sz(grp_sz), .gidx(req_gidx)
  );

  wpg_index #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .BASE_LOG2(BASE_LOG2)) u_chk_idx (
    .addr(chk_addr), .sz(grp_sz), .gidx(chk_gidx)
  );

  wpg_table #(.NGROUPS(NGROUPS), .ADDR_W(ADDR_W), .WIN(WIN)) u_table (
    .clk(clk), .rst(rst),
    .set_en(accept && grp_en && op == OP_SET),
    .clr_en(accept && grp_en && op == OP_CLR),
    .wr_idx(req_gidx), .rd_idx(chk_gidx), .base(req_gidx),
    .bits(grp_bits), .rd_bit(rd_bit), .window(window)
  );

  wpg_serializer #(.WIN(WIN)) u_ser (
    .clk(clk), .rst(rst),
    .load(accept && op == OP_QRY), .data(window),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_bit(rsp_bit), .rsp_last(rsp_last)
  );

  assign wr_permit = !(perm_wp || temp_wp || sw_wp || (grp_en && rd_bit));
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int NGROUPS = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_op,
  input logic               grp_en,
  input logic               perm_wp,
  input logic               temp_wp,
  input logic               sw_wp,
  input logic               wr_permit,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_bit,
  input logic               rsp_last,
  input logic [NGROUPS-1:0] grp_bits
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bit) && $stable(rsp_last)); // R9
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R9
  AST_QUERY_STARTS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_op == 2'd2 |=> rsp_valid); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready && rsp_last |=> !rsp_valid); // R8
  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !grp_en && req_valid && req_ready |=> $stable(grp_bits)); // R4
  AST_NOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_op == 2'd3 |=> $stable(grp_bits)); // R10
  AST_CARD_LOCK: assert property (@(posedge clk) disable iff (rst)
    (perm_wp || temp_wp || sw_wp) |-> !wr_permit); // R5
  AST_QUERY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_op == 2'd2 |=> $stable(grp_bits)); // R7
endmodule

bind wp_group_mgr wpg_checker #(.NGROUPS(NGROUPS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .grp_en(grp_en), .perm_wp(perm_wp), .temp_wp(temp_wp),
  .sw_wp(sw_wp), .wr_permit(wr_permit), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_bit(rsp_bit), .rsp_last(rsp_last),
  .grp_bits(grp_bits)
);

// File: tb/wp_group_mgr_tb_top.sv
module wp_group_mgr_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic        req_ready;
  logic [1:0]  req_op = 0;
  logic [31:0] req_addr = 0;
  logic [3:0]  grp_sz = 0;
  logic        grp_en = 1;
  logic        perm_wp = 0, temp_wp = 0, sw_wp = 0;
  logic [31:0] chk_addr = 0;
  logic        wr_permit;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic        rsp_bit;
  logic        rsp_last;

  int n_chk = 0;
  int n_fail = 0;
  bit mdl [64];

  always #5 clk = ~clk;

  wp_group_mgr dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .grp_sz(grp_sz), .grp_en(grp_en),
    .perm_wp(perm_wp), .temp_wp(temp_wp), .sw_wp(sw_wp), .chk_addr(chk_addr),
    .wr_permit(wr_permit), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_bit(rsp_bit), .rsp_last(rsp_last)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gaddr(input int g, input int junk);
    int sh = 9 + int'(grp_sz);
    return (32'(g) << sh) | (32'(junk) & ((32'd1 << sh) - 1));
  endfunction

  task automatic do_req(input logic [1:0] op, input logic [31:0] a);
    int g = int'(a >> (9 + int'(grp_sz)));
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (grp_en && g < 64 && op == 2'd0) mdl[g] = 1;
    if (grp_en && g < 64 && op == 2'd1) mdl[g] = 0;
  endtask

  // Sweep groups 0..69 at the check port and compare with the model.
  task automatic sweep(input string req);
    for (int g = 0; g < 70; g++) begin
      bit prot;
      chk_addr = gaddr(g, g * 37 + 5);
      #1;
      prot = perm_wp || temp_wp || sw_wp || (grp_en && g < 64 && mdl[g]);
      check(wr_permit == !prot, req, 64'(wr_permit), 64'(!prot));
    end
  endtask

  task automatic query(input logic [31:0] a, input bit stall, input string req);
    logic [47:0] exp, got;
    logic [15:0] c;
    int base, n, k;
    bit held, prev_b, prev_l, hold_ok, last_ok;
    base = int'(a >> (9 + int'(grp_sz)));
    c = 0;
    for (int i = 0; i < 32; i++) begin
      bit b = (base + i < 64) ? mdl[base + i] : 1'b0;
      exp[47 - i] = b;
      c = (c << 1) ^ ((b ^ c[15]) ? 16'h1021 : 16'h0);
    end
    exp[15:0] = c;
    do_req(2'd2, a);
    check(rsp_valid && !req_ready, "R9 busy", {62'd0, rsp_valid, req_ready}, 64'd2);
    n = 0; k = 0; held = 0; hold_ok = 1; last_ok = 1; got = 0;
    while (n < 48 && k < 400) begin
      bit rdy = !(stall && (k % 3 == 1));
      rsp_ready = rdy;
      if (rsp_valid) begin
        if (held && (rsp_bit != prev_b || rsp_last != prev_l)) hold_ok = 0;
        if (rdy) begin
          got[47 - n] = rsp_bit;
          if (rsp_last != (n == 47)) last_ok = 0;
          n++;
        end
        held = !rdy; prev_b = rsp_bit; prev_l = rsp_last;
      end
      k++;
      @(negedge clk);
    end
    rsp_ready = 1;
    check(got == exp, {req, " R7 R8 data+crc"}, 64'(got), 64'(exp));
    check(last_ok, "R8 last", 64'(last_ok), 64'd1);
    if (stall) check(hold_ok, "R9 hold", 64'(hold_ok), 64'd1);
    check(!rsp_valid && req_ready, "R9 idle", {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1 reset", {62'd0, req_ready, rsp_valid}, 64'd2);
    sweep("R1 R6 reset table");
    // R2 R3: group size 1 sector, junk low bits
    grp_sz = 0;
    foreach (mdl[i]) if (i == 0 || i == 5 || i == 31 || i == 32 || i == 63) do_req(2'd0, gaddr(i, 511));
    sweep("R3 R6 after sets");
    query(gaddr(0, 100), 0, "R7 base0");
    query(gaddr(33, 7), 0, "R7 base33");
    query(gaddr(50, 3), 1, "R9 stalled base50");
    query(gaddr(63, 0), 0, "R7 beyond range");
    do_req(2'd1, gaddr(5, 300));
    sweep("R3 clear");
    do_req(2'd0, gaddr(70, 1));
    sweep("R10 out of range set");
    do_req(2'd3, gaddr(20, 0));
    sweep("R10 nop");
    // R2: larger group size changes the mapping
    grp_sz = 2;
    do_req(2'd0, gaddr(3, 2047));
    do_req(2'd0, gaddr(9, 1));
    sweep("R2 grp_sz=2");
    query(gaddr(0, 1500), 1, "R2 query sz2");
    // R4: disabled
    grp_en = 0;
    do_req(2'd0, gaddr(10, 0));
    do_req(2'd1, gaddr(0, 0));
    sweep("R4 disabled permit");
    grp_en = 1;
    sweep("R4 bits unchanged");
    // R5: whole-card overrides
    perm_wp = 1; sweep("R5 perm"); perm_wp = 0;
    temp_wp = 1; sweep("R5 temp"); temp_wp = 0;
    sw_wp = 1; do_req(2'd0, gaddr(12, 0)); sweep("R5 switch"); sw_wp = 0;
    sweep("R5 bits kept");
    query(gaddr(0, 0), 0, "R5 query after overrides");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule